// File: doc/BRIEF.md
# Instruction Sequencer with Branch Unit

This block produces the address of the next instruction on every cycle. On sequential flow it adds the byte length of the current instruction to the current address. The length comes straight from the two most significant opcode bits. When a branch is taken, the target address supplied by the decoder is used instead. Conditional branches are decided by testing a four-bit mask against the two-bit condition code. Any single code, or any mix of the four codes, can therefore be named as the branch criterion.

Link-style branches also return the updated sequential address, so that the register file can keep it as a return point. The block holds the current instruction address in its own register. That register advances whenever the decoder marks the presented instruction fields as valid. Fetch memory, the register file and the arithmetic that sets the condition code all sit outside this block.

A target with its least significant bit set cannot start an instruction. A branch to such a target is refused and flagged as a specification error, and flow falls through to the sequential address.

Top module: `instr_sequencer`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `cur_addr` is loaded with `RESET_ADDR` (default 24'h000400).
- R2: `ilc` decodes `opc_len` as follows: 2'b00 gives 1, 2'b01 and 2'b10 give 2, and 2'b11 gives 3 halfwords.
- R3: With no branch taken and no specification error, `next_addr` equals `cur_addr + 2*ilc`. `link_addr` always carries that same sequential address.
- R4: All address sums wrap modulo 2^24. For example, 24'hFFFFFC plus 6 bytes gives 24'h000002.
- R5: For a conditional kind, the condition is met when the mask bit chosen by `cc` is set. `cc`=0 selects `mask[3]`, 1 selects `mask[2]`, 2 selects `mask[1]` and 3 selects `mask[0]`.
- R6: A mask of 4'b1111 meets the condition for every `cc` value. A mask of 4'b0000 never meets it.
- R7: `br_kind` encodes four kinds: 2'b00 is no branch, 2'b01 is conditional, 2'b10 is an unconditional link branch (the mask and `cc` are ignored), and 2'b11 is a conditional link branch.
- R8: When the branch condition is met and `target[0]` is 1, `spec_err` is 1, `taken` is 0 and `next_addr` is the sequential address. When the condition is met and the target is even, `taken` is 1 and `next_addr` equals `target`.
- R9: At a rising edge with `rst_n` high, `cur_addr` loads `next_addr` if `inst_valid` is 1, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| inst_valid | input | 1 | Presented instruction fields are valid; advance the address register |
| opc_len | input | 2 | Two most significant opcode bits (length code) |
| br_kind | input | 2 | Branch kind: 00 none, 01 conditional, 10 link, 11 conditional link |
| mask | input | 4 | Branch mask field |
| cc | input | 2 | Current condition code |
| target | input | 24 | Branch target address |
| cur_addr | output | 24 | Address of the current instruction |
| next_addr | output | 24 | Address of the next instruction |
| taken | output | 1 | Branch taken this cycle |
| link_addr | output | 24 | Updated sequential address for linkage |
| ilc | output | 2 | Instruction length code in halfwords |
| spec_err | output | 1 | Branch refused due to an odd target |

## Verification
Most state here is combinational from the inputs and the single address register, so a wrong decode shows on `next_addr`, `ilc` or `taken` in the same cycle the fields are presented. A corrupted address register shows one edge later, as a `cur_addr` that disagrees with the previous `next_addr`. After that, every sequential sum is offset by the same amount until the next taken branch overwrites it. A mask-bit ordering error appears only for the particular `cc` values it swaps, so every code is driven with single-bit masks.

// File: rtl/seq_pkg.sv
// Package: shared types for the instruction sequencer.
// Assumes byte addressing and instructions aligned to halfwords.
package seq_pkg;

    // Branch kind: bit 0 = condition tested, bit 1 = link requested
    typedef enum logic [1:0] {
        BK_NONE  = 2'b00,
        BK_COND  = 2'b01,
        BK_LINK  = 2'b10,
        BK_CLINK = 2'b11
    } br_kind_e;

    localparam int unsigned HW_BYTES = 2;

endpackage

// File: rtl/seq_len_decode.sv
// Module: seq_len_decode
// Turns the two top opcode bits into a halfword count (ilc) and a
// byte length of width AW. Assumes encoding 00->1, 01/10->2, 11->3.
module seq_len_decode #(
    parameter int unsigned AW = 24
) (
    input  logic [1:0]    opc_len,
    output logic [1:0]    ilc,
    output logic [AW-1:0] byte_len
);
    import seq_pkg::*;

    // Map the length code to a halfword count
    always_comb begin
        unique case (opc_len)
            2'b00:   ilc = 2'd1;
            2'b11:   ilc = 2'd3;
            default: ilc = 2'd2;
        endcase
    end

    // Scale halfwords to bytes
    always_comb begin
        byte_len = AW'(ilc) * AW'(HW_BYTES);
    end

endmodule

// File: rtl/seq_cond_eval.sv
// Module: seq_cond_eval
// Selects one mask bit per condition-code value. The most significant
// mask bit belongs to code 0, the least significant to the highest code.
// Assumes MW = 2**CCW.
module seq_cond_eval #(
    parameter int unsigned CCW = 2,
    localparam int unsigned MW = 1 << CCW
) (
    input  logic [MW-1:0]  mask,
    input  logic [CCW-1:0] cc,
    output logic           hit
);
    logic [MW-1:0] sel;

    // One comparator per mask bit
    for (genvar i = 0; i < MW; i++) begin : g_sel
        always_comb begin
            sel[i] = mask[i] && (cc == CCW'(MW - 1 - i));
        end
    end

    // Condition met when the selected bit is set
    always_comb begin
        hit = |sel;
    end

endmodule

// File: rtl/seq_target_sel.sv
// Module: seq_target_sel
// Picks the branch target or the sequential address. Refuses odd
// targets and raises spec_err instead. Assumes want_branch already
// combines kind and condition.
module seq_target_sel #(
    parameter int unsigned AW = 24
) (
    input  logic          want_branch,
    input  logic [AW-1:0] target,
    input  logic [AW-1:0] seq_addr,
    output logic [AW-1:0] next_addr,
    output logic          taken,
    output logic          spec_err
);
    // Alignment trap and taken decision
    always_comb begin
        spec_err = want_branch && target[0];
        taken    = want_branch && !target[0];
    end

    // Address multiplexer
    always_comb begin
        next_addr = taken ? target : seq_addr;
    end

endmodule

// File: rtl/instr_sequencer.sv
// Module: instr_sequencer (top)
// Holds the current instruction address and computes the next one from
// the length code, branch kind, mask, condition code and target.
// Assumes RESET_ADDR is even; sums wrap modulo 2**AW.
module instr_sequencer #(
    parameter int unsigned  AW         = 24,
    parameter int unsigned  CCW        = 2,
    parameter logic [AW-1:0] RESET_ADDR = 24'h000400,
    localparam int unsigned MW         = 1 << CCW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           inst_valid,
    input  logic [1:0]     opc_len,
    input  logic [1:0]     br_kind,
    input  logic [MW-1:0]  mask,
    input  logic [CCW-1:0] cc,
    input  logic [AW-1:0]  target,
    output logic [AW-1:0]  cur_addr,
    output logic [AW-1:0]  next_addr,
    output logic           taken,
    output logic [AW-1:0]  link_addr,
    output logic [1:0]     ilc,
    output logic           spec_err
);
    import seq_pkg::*;

    logic [AW-1:0] byte_len;
    logic [AW-1:0] seq_addr;
    logic          cond_hit;
    logic          want_branch;
    br_kind_e      kind;

    seq_len_decode #(.AW(AW)) u_len (
        .opc_len  (opc_len),
        .ilc      (ilc),
        .byte_len (byte_len)
    );

    seq_cond_eval #(.CCW(CCW)) u_cond (
        .mask (mask),
        .cc   (cc),
        .hit  (cond_hit)
    );

    // Sequential address, wrapping at the address width
    always_comb begin
        seq_addr  = cur_addr + byte_len;
        link_addr = seq_addr;
    end

    // Branch request from kind and condition
    always_comb begin
        kind = br_kind_e'(br_kind);
        unique case (kind)
            BK_NONE:  want_branch = 1'b0;
            BK_LINK:  want_branch = 1'b1;
            default:  want_branch = cond_hit;
        endcase
    end

    seq_target_sel #(.AW(AW)) u_sel (
        .want_branch (want_branch),
        .target      (target),
        .seq_addr    (seq_addr),
        .next_addr   (next_addr),
        .taken       (taken),
        .spec_err    (spec_err)
    );

    // Current-address register
    always_ff @(posedge clk) begin
        if (!rst_n)          cur_addr <= RESET_ADDR;
        else if (inst_valid) cur_addr <= next_addr;
    end

    // R9
    pc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inst_valid |=> cur_addr == $past(next_addr));
    // R9
    pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !inst_valid |=> $stable(cur_addr));
    // R8
    taken_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> (next_addr == target) && !target[0]);
    // R8
    spec_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spec_err |-> !taken && (next_addr == link_addr));
    // R6
    mask_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_kind[0] && mask == '0) |-> !taken && !spec_err);
    // R7
    link_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_kind == 2'b10 && !target[0]) |-> taken);
    // R3
    seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_kind == 2'b00) |-> next_addr == link_addr);

endmodule

// File: tb/sim_instr_sequencer.sv
// Bench for instr_sequencer: table walk then directed tests.
module sim_instr_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        inst_valid = 1'b0;
    logic [1:0]  opc_len = '0;
    logic [1:0]  br_kind = '0;
    logic [3:0]  mask = '0;
    logic [1:0]  cc = '0;
    logic [23:0] target = '0;
    logic [23:0] cur_addr, next_addr, link_addr;
    logic        taken, spec_err;
    logic [1:0]  ilc;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    instr_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .inst_valid(inst_valid), .opc_len(opc_len),
        .br_kind(br_kind), .mask(mask), .cc(cc), .target(target),
        .cur_addr(cur_addr), .next_addr(next_addr), .taken(taken),
        .link_addr(link_addr), .ilc(ilc), .spec_err(spec_err)
    );

    // kind, op, mask, cc, target, exp_next, exp_taken, exp_spec (cur = 0x400)
    localparam int NV = 18;
    localparam logic [59:0] VEC [NV] = '{
        {2'b00, 2'b00, 4'b0000, 2'd0, 24'h000000, 24'h000402, 1'b0, 1'b0},
        {2'b00, 2'b01, 4'b0000, 2'd0, 24'h000000, 24'h000404, 1'b0, 1'b0},
        {2'b00, 2'b10, 4'b1111, 2'd0, 24'h000800, 24'h000404, 1'b0, 1'b0},
        {2'b00, 2'b11, 4'b0000, 2'd0, 24'h000000, 24'h000406, 1'b0, 1'b0},
        {2'b01, 2'b01, 4'b1000, 2'd0, 24'h001000, 24'h001000, 1'b1, 1'b0},
        {2'b01, 2'b01, 4'b1000, 2'd1, 24'h001000, 24'h000404, 1'b0, 1'b0},
        {2'b01, 2'b01, 4'b0100, 2'd1, 24'h002000, 24'h002000, 1'b1, 1'b0},
        {2'b01, 2'b00, 4'b0010, 2'd2, 24'h003000, 24'h003000, 1'b1, 1'b0},
        {2'b01, 2'b00, 4'b0001, 2'd3, 24'h003002, 24'h003002, 1'b1, 1'b0},
        {2'b01, 2'b00, 4'b0111, 2'd0, 24'h003000, 24'h000402, 1'b0, 1'b0},
        {2'b01, 2'b10, 4'b1111, 2'd3, 24'hABCDE0, 24'hABCDE0, 1'b1, 1'b0},
        {2'b01, 2'b10, 4'b0000, 2'd0, 24'h000500, 24'h000404, 1'b0, 1'b0},
        {2'b10, 2'b00, 4'b0000, 2'd2, 24'h000600, 24'h000600, 1'b1, 1'b0},
        {2'b11, 2'b11, 4'b0101, 2'd1, 24'h000700, 24'h000700, 1'b1, 1'b0},
        {2'b11, 2'b11, 4'b0101, 2'd0, 24'h000700, 24'h000406, 1'b0, 1'b0},
        {2'b01, 2'b01, 4'b1000, 2'd0, 24'h001001, 24'h000404, 1'b0, 1'b1},
        {2'b10, 2'b00, 4'b0000, 2'd0, 24'h000777, 24'h000402, 1'b0, 1'b1},
        {2'b01, 2'b01, 4'b0000, 2'd0, 24'h001001, 24'h000404, 1'b0, 1'b0}
    };

    // Compare and report one value
    task automatic chk(input string req, input string what,
                       input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Drive instruction fields at a falling edge
    task automatic drive(input logic v, input logic [1:0] k, input logic [1:0] op,
                         input logic [3:0] m, input logic [1:0] c, input logic [23:0] t);
        @(negedge clk);
        inst_valid = v; br_kind = k; opc_len = op; mask = m; cc = c; target = t;
        #1;
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        chk("R1", "cur_addr after reset", cur_addr, 24'h000400);
        rst_n = 1'b1;

        // Table walk, inst_valid low so cur_addr stays at 0x400 (R2 R3 R5 R6 R7 R8)
        for (int i = 0; i < NV; i++) begin
            logic [1:0] exp_ilc;
            drive(1'b0, VEC[i][59:58], VEC[i][57:56], VEC[i][55:52],
                  VEC[i][51:50], VEC[i][49:26]);
            exp_ilc = (VEC[i][57:56] == 2'b00) ? 2'd1 :
                      (VEC[i][57:56] == 2'b11) ? 2'd3 : 2'd2;
            chk("R2", $sformatf("ilc vec %0d", i), 24'(ilc), 24'(exp_ilc));
            chk("R3", $sformatf("link_addr vec %0d", i), link_addr,
                24'h000400 + 24'(exp_ilc) * 24'd2);
            chk("R5", $sformatf("next_addr vec %0d", i), next_addr, VEC[i][25:2]);
            chk("R7", $sformatf("taken vec %0d", i), 24'(taken), 24'(VEC[i][1]));
            chk("R8", $sformatf("spec_err vec %0d", i), 24'(spec_err), 24'(VEC[i][0]));
        end

        // R6: full mask for every code, empty mask for every code
        for (int c = 0; c < 4; c++) begin
            drive(1'b0, 2'b01, 2'b00, 4'b1111, 2'(c), 24'h000A00);
            chk("R6", "mask 1111 taken", 24'(taken), 24'd1);
            drive(1'b0, 2'b01, 2'b00, 4'b0000, 2'(c), 24'h000A00);
            chk("R6", "mask 0000 not taken", 24'(taken), 24'd0);
        end

        // R9: sequential step loads the register
        drive(1'b1, 2'b00, 2'b11, 4'b0000, 2'd0, 24'h0);
        drive(1'b0, 2'b10, 2'b00, 4'b0000, 2'd0, 24'h000900);
        chk("R9", "cur_addr after step", cur_addr, 24'h000406);
        // R9: hold while inst_valid low despite a link request
        drive(1'b0, 2'b00, 2'b00, 4'b0000, 2'd0, 24'h0);
        chk("R9", "cur_addr held", cur_addr, 24'h000406);

        // R4: jump near the top, then wrap
        drive(1'b1, 2'b10, 2'b00, 4'b0000, 2'd0, 24'hFFFFFC);
        drive(1'b0, 2'b00, 2'b11, 4'b0000, 2'd0, 24'h0);
        chk("R4", "cur_addr at top", cur_addr, 24'hFFFFFC);
        chk("R4", "wrapped next_addr", next_addr, 24'h000002);
        drive(1'b1, 2'b00, 2'b11, 4'b0000, 2'd0, 24'h0);
        drive(1'b0, 2'b00, 2'b00, 4'b0000, 2'd0, 24'h0);
        chk("R4", "wrapped cur_addr", cur_addr, 24'h000002);

        // R8: odd target with valid falls through
        drive(1'b1, 2'b01, 2'b00, 4'b1111, 2'd2, 24'h000005);
        drive(1'b0, 2'b00, 2'b00, 4'b0000, 2'd0, 24'h0);
        chk("R8", "cur_addr after refused branch", cur_addr, 24'h000004);

        // R1: reset mid-run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); #1;
        chk("R1", "cur_addr after mid-run reset", cur_addr, 24'h000400);
        rst_n = 1'b1;

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule